// File: doc/BRIEF.md
# Tagged Register File Dispatch Unit

This block sits between an in-order instruction queue and a set of reservation stations. It owns a small architected register file. Each register keeps a data value and a pending-producer tag. Instructions use a two-operand form: the first register named is both a source and the destination, and the second register is the other source. Instructions wait in an eight-entry queue and leave it one at a time. An instruction leaves only when a station of its kind is free.

At dispatch, each source is handed to the station in one of two forms. If the register has no producer in flight, the unit sends its value. Otherwise it sends the tag of the producer that will write it. The destination register then takes the tag of the station that was just allocated, replacing any older tag. The unit snoops the shared result bus. A register accepts a broadcast result only if the broadcast tag equals the tag the register currently holds. Because of this, a slow older producer cannot overwrite the result of a newer one, and no reorder buffering is needed. Execution inside the stations is handled elsewhere.

Top module: `tag_dispatch_top`

## Requirements
- R1: After synchronous active-high reset, every register value is zero and every register tag is 0 ("no pending write"). The queue is empty, `in_ready` is 1 and `disp_valid` is 0.
- R2: The queue holds up to 8 instructions. While 8 are held, `in_ready` is 0, and an offered instruction is not accepted.
- R3: Add-type instructions (`in_kind`=0) go to add stations with tags 1..3, where `free_add[i]` means station i+1 is free. Multiply/divide-type instructions (`in_kind`=1) go to stations with tags 4..5, where `free_mul[j]` means station 4+j is free. The lowest-numbered free station of the needed kind is chosen and reported on `disp_station`.
- R4: A source register whose tag is 0 is sent with rdy=1, its value, and tag 0.
- R5: A source register with a nonzero tag is sent with rdy=0 and that tag.
- R6: On dispatch, the destination register's tag becomes the allocated station tag, even if an older write is still pending.
- R7: A result broadcast whose tag equals a register's nonzero tag writes the data into that register and clears the tag. A broadcast with any other tag leaves the register unchanged.
- R8: If a source register's tag matches a result broadcast in the same cycle as dispatch, the station receives rdy=1 and the broadcast data.
- R9: At most one instruction dispatches per cycle, in queue order. If no station of the head's kind is free, the head and every younger instruction wait.
- R10: The first source is read with the destination register's tag as it stood before this instruction renamed it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered to the queue |
| in_ready | output | 1 | Queue can accept an instruction |
| in_kind | input | 1 | 0 add-type, 1 multiply/divide-type |
| in_dst | input | 2 | First register: destination and first source |
| in_src | input | 2 | Second source register |
| free_add | input | 3 | Free flag per add station |
| free_mul | input | 2 | Free flag per multiply/divide station |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | 3 | Tag of the broadcasting producer |
| cdb_data | input | 16 | Broadcast result |
| disp_valid | output | 1 | An instruction dispatches this cycle |
| disp_kind | output | 1 | Kind of the dispatched instruction |
| disp_station | output | 3 | Tag of the allocated station |
| disp_a_rdy | output | 1 | First operand holds a value |
| disp_a_tag | output | 3 | First operand pending tag |
| disp_a_val | output | 16 | First operand value |
| disp_b_rdy | output | 1 | Second operand holds a value |
| disp_b_tag | output | 3 | Second operand pending tag |
| disp_b_val | output | 16 | Second operand value |

## Verification
The bench uses the default parameters: four registers, 16-bit data, three add stations, two multiply/divide stations and an eight-deep queue. These sizes are small enough to fill the queue completely and to run out of stations of one kind while the other kind is still free, so the full-queue and in-order stall cases can be reached. With only three add stations, a register can be renamed twice while its first producer is still pending, and that first producer's late broadcast can then be shown to have no effect.

// File: rtl/tdu_pkg.sv
package tdu_pkg;
    localparam int NREG   = 4;
    localparam int DW     = 16;
    localparam int N_ADD  = 3;
    localparam int N_MUL  = 2;
    localparam int QDEPTH = 8;

    localparam int RIDX = $clog2(NREG);
    localparam int NST  = N_ADD + N_MUL;
    localparam int TAGW = $clog2(NST + 1);

    typedef logic [TAGW-1:0] tag_t;
    typedef logic [DW-1:0]   data_t;
    typedef logic [RIDX-1:0] ridx_t;

    typedef enum logic {OP_ADD = 1'b0, OP_MUL = 1'b1} opk_t;

    typedef struct packed {
        opk_t  kind;
        ridx_t dst;
        ridx_t src;
    } instr_t;

    typedef struct packed {
        logic  rdy;
        tag_t  tag;
        data_t val;
    } opnd_t;

    localparam tag_t NO_TAG = '0;

    function automatic opnd_t read_opnd(input data_t v, input tag_t t,
                                        input logic bv, input tag_t bt,
                                        input data_t bd);
        opnd_t o;
        if (t == NO_TAG) begin
            o.rdy = 1'b1; o.tag = NO_TAG; o.val = v;
        end else if (bv && bt == t) begin
            o.rdy = 1'b1; o.tag = NO_TAG; o.val = bd;
        end else begin
            o.rdy = 1'b0; o.tag = t; o.val = '0;
        end
        return o;
    endfunction
endpackage

// File: rtl/td_queue.sv
module td_queue
    import tdu_pkg::*;
#(
    parameter int DEPTH = QDEPTH
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push_valid,
    output logic   push_ready,
    input  instr_t push_data,
    output logic   head_valid,
    output instr_t head_data,
    input  logic   pop
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    instr_t         mem [DEPTH];
    logic [PW-1:0]  wr_ptr, rd_ptr;
    logic [CW-1:0]  cnt;
    logic           do_push, do_pop;

    assign push_ready = (cnt != CW'(DEPTH));
    assign head_valid = (cnt != '0);
    assign head_data  = mem[rd_ptr];
    assign do_push    = push_valid && push_ready;
    assign do_pop     = pop && head_valid;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (do_push) begin
                mem[wr_ptr] <= push_data;
                wr_ptr      <= nxt(wr_ptr);
            end
            if (do_pop) rd_ptr <= nxt(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R2: a full queue stays full unless an entry leaves
    a_r2_full_holds: assert property (@(posedge clk) disable iff (rst)
        (cnt == CW'(DEPTH) && !pop) |=> cnt == CW'(DEPTH));
    // R9: a waiting head keeps its contents
    a_r9_head_stable: assert property (@(posedge clk) disable iff (rst)
        (head_valid && !pop) |=> head_valid && $stable(head_data));
endmodule

// File: rtl/td_pick.sv
module td_pick
    import tdu_pkg::*;
#(
    parameter int N    = N_ADD,
    parameter int BASE = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] free,
    output logic         found,
    output tag_t         id
);
    logic [N-1:0] grant;

    always_comb begin
        found = 1'b0;
        id    = NO_TAG;
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free[i]) begin
                found = 1'b1;
                id    = tag_t'(BASE + i);
                grant = N'(1) << i;
            end
        end
    end

    // R3: at most one station granted, and only a free one
    a_r3_grant_free: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && ((grant & ~free) == '0));
endmodule

// File: rtl/td_regs.sv
module td_regs
    import tdu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ridx_t rd_a,
    input  ridx_t rd_b,
    output opnd_t opnd_a,
    output opnd_t opnd_b,
    input  logic  ren_valid,
    input  ridx_t ren_idx,
    input  tag_t  ren_tag,
    input  logic  cdb_valid,
    input  tag_t  cdb_tag,
    input  data_t cdb_data
);
    data_t val_q [NREG];
    tag_t  tag_q [NREG];

    assign opnd_a = read_opnd(val_q[rd_a], tag_q[rd_a], cdb_valid, cdb_tag, cdb_data);
    assign opnd_b = read_opnd(val_q[rd_b], tag_q[rd_b], cdb_valid, cdb_tag, cdb_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) begin
                val_q[i] <= '0;
                tag_q[i] <= NO_TAG;
            end
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (cdb_valid && tag_q[i] != NO_TAG && cdb_tag == tag_q[i]) begin
                    val_q[i] <= cdb_data;
                    tag_q[i] <= NO_TAG;
                end
                if (ren_valid && ren_idx == ridx_t'(i))
                    tag_q[i] <= ren_tag;
            end
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_chk
        // R7: a value changes only by a matching broadcast
        a_r7_stale_ignored: assert property (@(posedge clk) disable iff (rst)
            !(cdb_valid && tag_q[g] != NO_TAG && cdb_tag == tag_q[g])
            |=> val_q[g] == $past(val_q[g]));
        // R6: renaming installs the new station tag
        a_r6_rename: assert property (@(posedge clk) disable iff (rst)
            (ren_valid && ren_idx == ridx_t'(g)) |=> tag_q[g] == $past(ren_tag));
    end
endmodule

// File: rtl/tag_dispatch_top.sv
module tag_dispatch_top
    import tdu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_kind,
    input  logic [RIDX-1:0]  in_dst,
    input  logic [RIDX-1:0]  in_src,
    input  logic [N_ADD-1:0] free_add,
    input  logic [N_MUL-1:0] free_mul,
    input  logic             cdb_valid,
    input  logic [TAGW-1:0]  cdb_tag,
    input  logic [DW-1:0]    cdb_data,
    output logic             disp_valid,
    output logic             disp_kind,
    output logic [TAGW-1:0]  disp_station,
    output logic             disp_a_rdy,
    output logic [TAGW-1:0]  disp_a_tag,
    output logic [DW-1:0]    disp_a_val,
    output logic             disp_b_rdy,
    output logic [TAGW-1:0]  disp_b_tag,
    output logic [DW-1:0]    disp_b_val
);
    instr_t in_instr, head;
    logic   head_valid, add_found, mul_found, st_ok, go;
    tag_t   add_id, mul_id, st_id;
    opnd_t  oa, ob;

    assign in_instr = '{kind: opk_t'(in_kind), dst: in_dst, src: in_src};

    td_queue #(.DEPTH(QDEPTH)) u_q (
        .clk(clk), .rst(rst),
        .push_valid(in_valid), .push_ready(in_ready), .push_data(in_instr),
        .head_valid(head_valid), .head_data(head), .pop(go)
    );

    td_pick #(.N(N_ADD), .BASE(1)) u_pick_add (
        .clk(clk), .rst(rst), .free(free_add), .found(add_found), .id(add_id)
    );
    td_pick #(.N(N_MUL), .BASE(N_ADD + 1)) u_pick_mul (
        .clk(clk), .rst(rst), .free(free_mul), .found(mul_found), .id(mul_id)
    );

    assign st_ok = (head.kind == OP_MUL) ? mul_found : add_found;
    assign st_id = (head.kind == OP_MUL) ? mul_id    : add_id;
    assign go    = head_valid && st_ok;

    td_regs u_rf (
        .clk(clk), .rst(rst),
        .rd_a(head.dst), .rd_b(head.src), .opnd_a(oa), .opnd_b(ob),
        .ren_valid(go), .ren_idx(head.dst), .ren_tag(st_id),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data)
    );

    assign disp_valid   = go;
    assign disp_kind    = head.kind;
    assign disp_station = st_id;
    assign disp_a_rdy   = oa.rdy;
    assign disp_a_tag   = oa.tag;
    assign disp_a_val   = oa.val;
    assign disp_b_rdy   = ob.rdy;
    assign disp_b_tag   = ob.tag;
    assign disp_b_val   = ob.val;

    // R3: a dispatched instruction never names the "no pending" tag as its station
    a_r3_station_nonzero: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> disp_station != NO_TAG);
    // R4/R5: a ready operand carries no tag, a waiting one carries a tag
    a_r5_tag_vs_rdy: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> (disp_a_rdy == (disp_a_tag == NO_TAG)) &&
                       (disp_b_rdy == (disp_b_tag == NO_TAG)));
endmodule

// File: tb/sim_tag_dispatch_top.sv
module sim_tag_dispatch_top;
    import tdu_pkg::*;

    logic clk = 1'b0, rst = 1'b1;
    logic in_valid = 1'b0, in_ready, in_kind = 1'b0;
    logic [RIDX-1:0] in_dst = '0, in_src = '0;
    logic [N_ADD-1:0] free_add = '1;
    logic [N_MUL-1:0] free_mul = '1;
    logic cdb_valid = 1'b0;
    logic [TAGW-1:0] cdb_tag = '0;
    logic [DW-1:0] cdb_data = '0;
    logic disp_valid, disp_kind, disp_a_rdy, disp_b_rdy;
    logic [TAGW-1:0] disp_station, disp_a_tag, disp_b_tag;
    logic [DW-1:0] disp_a_val, disp_b_val;

    tag_dispatch_top u0 (.*);

    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0, n_disp = 0;
    instr_t expq[$];
    data_t m_val [NREG];
    tag_t  m_tag [NREG];
    tag_t  l_st, l_atag, l_btag;
    logic  l_ardy, l_brdy;
    data_t l_aval, l_bval;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic opnd_t mdl_read(input ridx_t r);
        opnd_t o;
        if (m_tag[r] == 0) begin o.rdy = 1; o.tag = 0; o.val = m_val[r]; end
        else if (cdb_valid && cdb_tag == m_tag[r]) begin o.rdy = 1; o.tag = 0; o.val = cdb_data; end
        else begin o.rdy = 0; o.tag = m_tag[r]; o.val = '0; end
        return o;
    endfunction

    // monitor: compares each dispatch against the reference model, then advances the model
    always @(negedge clk) begin
        if (!rst) begin
            tag_t  est;
            opnd_t ea, eb;
            instr_t e;
            est = '0; ea = '0; eb = '0; e = '0;
            if (disp_valid) begin
                if (expq.size() == 0) chk("R9 unexpected dispatch", 1, 0);
                else begin
                    e = expq.pop_front();
                    if (e.kind == OP_MUL) begin
                        for (int j = N_MUL - 1; j >= 0; j--) if (free_mul[j]) est = tag_t'(N_ADD + 1 + j);
                    end else begin
                        for (int i = N_ADD - 1; i >= 0; i--) if (free_add[i]) est = tag_t'(1 + i);
                    end
                    ea = mdl_read(e.dst);
                    eb = mdl_read(e.src);
                    chk("R9 order kind", disp_kind, e.kind);
                    chk("R3 station", disp_station, est);
                    chk("R4/R5/R8 a rdy", disp_a_rdy, ea.rdy);
                    chk("R5/R10 a tag", disp_a_tag, ea.tag);
                    if (ea.rdy) chk("R4/R8 a val", disp_a_val, ea.val);
                    chk("R4/R5/R8 b rdy", disp_b_rdy, eb.rdy);
                    chk("R5 b tag", disp_b_tag, eb.tag);
                    if (eb.rdy) chk("R4/R8 b val", disp_b_val, eb.val);
                    l_st = disp_station; l_ardy = disp_a_rdy; l_atag = disp_a_tag; l_aval = disp_a_val;
                    l_brdy = disp_b_rdy; l_btag = disp_b_tag; l_bval = disp_b_val;
                    n_disp++;
                end
            end
            for (int r = 0; r < NREG; r++)
                if (cdb_valid && m_tag[r] != 0 && cdb_tag == m_tag[r]) begin
                    m_val[r] = cdb_data; m_tag[r] = 0;
                end
            if (disp_valid && expq.size() >= 0 && est != 0) m_tag[e.dst] = est;
        end
    end

    task automatic push(input logic k, input ridx_t d, input ridx_t s);
        @(posedge clk); #1;
        while (!in_ready) begin @(posedge clk); #1; end
        in_valid = 1; in_kind = k; in_dst = d; in_src = s;
        expq.push_back('{kind: opk_t'(k), dst: d, src: s});
        @(posedge clk); #1;
        in_valid = 0;
    endtask

    task automatic bcast(input tag_t t, input data_t v);
        @(posedge clk); #1;
        cdb_valid = 1; cdb_tag = t; cdb_data = v;
        @(posedge clk); #1;
        cdb_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int base;
        for (int r = 0; r < NREG; r++) begin m_val[r] = '0; m_tag[r] = '0; end
        repeat (3) @(posedge clk);
        #1 rst = 0;
        #1;
        chk("R1 in_ready after reset", in_ready, 1);
        chk("R1 no dispatch after reset", disp_valid, 0);

        // R4: clean registers go as values
        push(0, 0, 1); idle(2);
        chk("R3 first add station", l_st, 1);
        chk("R4 a ready", l_ardy, 1);
        chk("R4 a value", l_aval, 0);

        // R5: pending register goes as tag
        push(1, 2, 0); idle(2);
        chk("R3 first mul station", l_st, 4);
        chk("R5 b not ready", l_brdy, 0);
        chk("R5 b tag", l_btag, 1);

        // R10 / R6: rename R0 again while tag 1 is pending
        free_add = 3'b110;
        push(0, 0, 3); idle(2);
        chk("R3 lowest free add", l_st, 2);
        chk("R10 a uses old tag", l_atag, 1);
        free_add = 3'b100;
        push(0, 1, 0); idle(2);
        chk("R6 newest tag on R0", l_btag, 2);

        // R7: stale broadcast of tag 1 is ignored for R0
        bcast(1, 16'hAAAA);
        free_add = 3'b111;
        push(0, 3, 0); idle(2);
        chk("R7 stale result ignored rdy", l_brdy, 0);
        chk("R7 stale result ignored tag", l_btag, 2);

        // R8: matching broadcast in the dispatch cycle is forwarded
        @(posedge clk); #1;
        in_valid = 1; in_kind = 0; in_dst = 2; in_src = 0;
        expq.push_back('{kind: OP_ADD, dst: 2'd2, src: 2'd0});
        @(posedge clk); #1;
        in_valid = 0; cdb_valid = 1; cdb_tag = 2; cdb_data = 16'h1234;
        @(posedge clk); #1;
        cdb_valid = 0;
        idle(1);
        chk("R8 forwarded rdy", l_brdy, 1);
        chk("R8 forwarded val", l_bval, 16'h1234);
        push(0, 1, 0); idle(2);
        chk("R7 latched value", l_bval, 16'h1234);

        // R9: mul head stalls, add behind it waits
        free_mul = '0;
        base = n_disp;
        push(1, 1, 2); push(0, 2, 1); idle(4);
        chk("R9 stalled head", n_disp - base, 0);
        free_mul = 2'b10;
        idle(4);
        chk("R9 both dispatched", n_disp - base, 2);

        // R2: fill the queue
        free_add = '0; free_mul = '0;
        for (int i = 0; i < QDEPTH; i++) push(0, ridx_t'(i % NREG), ridx_t'((i + 1) % NREG));
        chk("R2 full deasserts ready", in_ready, 0);
        @(posedge clk); #1; in_valid = 1; in_kind = 1; in_dst = 3; in_src = 3;
        @(posedge clk); #1; in_valid = 0;
        base = n_disp;
        free_add = '1;
        idle(20);
        chk("R2 eight drained", n_disp - base, QDEPTH);
        chk("R2 nothing extra", expq.size(), 0);
        chk("R9 idle when empty", disp_valid, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule